// File: doc/BRIEF.md
# Registered Status-Flag Arithmetic Unit

This block performs addition, subtraction and the three bitwise operations AND, OR and XOR. The operand size is 8, 16 or 32 bits, chosen on every request. For each request it produces the result and six status flags: carry, parity, auxiliary carry, zero, sign and overflow. Every flag is computed at the selected operand size, in the manner of a conventional 32-bit processor flags register. A datapath instantiates it wherever an integer operation must feed condition codes to later logic.

A request is a single-cycle strobe that carries an operation code, a size code and two operands. The result and flags are captured in registers. They appear together with an output valid pulse on the clock edge after the strobe. A two-state machine tracks whether the output registers hold a fresh result:
- IDLE: no new result this cycle. IDLE goes to OUT when a strobe arrives and stays in IDLE otherwise.
- OUT: a result is presented. OUT stays in OUT on another strobe and returns to IDLE when there is none.

A strobe can arrive on every cycle, so the unit accepts back-to-back requests.

Top module: `stat_alu`

## Requirements
- R1: While reset is asserted and after it is released, with no strobe given, `out_valid` is 0, `result` is 0 and `flags` is 0.
- R2: `out_valid` is 1 in exactly the cycle after each cycle in which `in_valid` was 1. Back-to-back strobes give back-to-back results.
- R3: Operation codes are 0 = add, 1 = subtract (a minus b), 2 = AND, 3 = OR, 4 = XOR. The result is the operation's value modulo 2^n, where n is the selected size.
- R4: `flags[0]` (carry) is the carry out of bit n-1 for add. For subtract it is the borrow, which is 1 exactly when a is unsigned-less than b.
- R5: `flags[5]` (overflow) is 1 when the signed two's-complement result at size n falls outside the representable range, for add and subtract.
- R6: `flags[4]` (sign) equals bit n-1 of the result. `flags[3]` (zero) is 1 exactly when the n-bit result is 0.
- R7: `flags[2]` (auxiliary carry) is the carry out of bit 3 for add and the borrow out of bit 3 for subtract. It is 0 for AND, OR and XOR.
- R8: `flags[1]` (parity) is 1 when bits 7:0 of the result contain an even number of ones, at every size.
- R9: AND, OR and XOR force carry and overflow to 0.
- R10: Codes 5, 6 and 7 yield result 0, with zero and parity set and all other flags 0.
- R11: In a cycle with no strobe, `result` and `flags` keep the values they held and `out_valid` is 0.
- R12: Size codes are 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. Operand bits above the selected size are ignored, and result bits above it are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 3 | Operation code |
| size_sel | input | 2 | Operand size code |
| opnd_a | input | DATA_W | First operand |
| opnd_b | input | DATA_W | Second operand |
| out_valid | output | 1 | Result and flags are fresh |
| result | output | DATA_W | Registered result, zero above the selected size |
| flags | output | 6 | {overflow, sign, zero, aux carry, parity, carry} |

## Verification
The state machine holds only one bit, so an error in it appears on `out_valid` in the cycle after the faulty strobe. It also appears at the first idle cycle as a result register that fails to hold. A wrong lane selection or a wrong carry tap shows on the first vector whose size or operands reach the affected bit, and always one cycle after that vector's strobe. The 8-bit sweep covers every carry, borrow and overflow case of a full operand pair. Corner operands at 16 and 32 bits catch a most-significant-bit tap placed at the wrong size.

// File: rtl/stat_alu_pkg.sv
package stat_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2
    } alu_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OUT  = 1'b1
    } out_state_e;

    localparam int NUM_FLAGS = 6;
    localparam int NUM_LANES = 3;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic aux;
        logic par;
        logic cry;
    } flags_t;

    function automatic logic is_bitwise(input logic [2:0] op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction

endpackage

// File: rtl/stat_alu_lane.sv
module stat_alu_lane
    import stat_alu_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    input  logic [2:0]        op,
    output logic [LANE_W-1:0] res,
    output logic              cry,
    output logic              ovf,
    output logic              aux,
    output logic              sgn
);

    localparam int MSB = LANE_W - 1;

    logic [LANE_W:0] sum_w;
    logic [LANE_W:0] dif_w;

    assign sum_w = {1'b0, a} + {1'b0, b};
    assign dif_w = {1'b0, a} - {1'b0, b};

    always_comb begin
        res = '0;
        cry = 1'b0;
        ovf = 1'b0;
        aux = 1'b0;
        unique case (op)
            OP_ADD: begin
                res = sum_w[MSB:0];
                cry = sum_w[LANE_W];
                ovf = (a[MSB] == b[MSB]) && (sum_w[MSB] != a[MSB]);
                aux = a[4] ^ b[4] ^ sum_w[4];
            end
            OP_SUB: begin
                res = dif_w[MSB:0];
                cry = dif_w[LANE_W];
                ovf = (a[MSB] != b[MSB]) && (dif_w[MSB] != a[MSB]);
                aux = a[4] ^ b[4] ^ dif_w[4];
            end
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            default: res = '0;
        endcase
        sgn = res[MSB];
    end

endmodule

// File: rtl/stat_alu_sel.sv
module stat_alu_sel
    import stat_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]                          size_sel,
    input  logic [NUM_LANES-1:0][DATA_W-1:0]    lane_res,
    input  logic [NUM_LANES-1:0]                lane_cry,
    input  logic [NUM_LANES-1:0]                lane_ovf,
    input  logic [NUM_LANES-1:0]                lane_aux,
    input  logic [NUM_LANES-1:0]                lane_sgn,
    output logic [DATA_W-1:0]                   sel_res,
    output flags_t                              sel_flags
);

    logic [1:0] lane_idx;

    always_comb begin
        unique case (size_sel)
            SZ_BYTE: lane_idx = 2'd0;
            SZ_WORD: lane_idx = 2'd1;
            default: lane_idx = 2'd2;
        endcase
    end

    always_comb begin
        sel_res       = lane_res[lane_idx];
        sel_flags.cry = lane_cry[lane_idx];
        sel_flags.ovf = lane_ovf[lane_idx];
        sel_flags.aux = lane_aux[lane_idx];
        sel_flags.sgn = lane_sgn[lane_idx];
        sel_flags.zro = (sel_res == '0);
        sel_flags.par = ~^sel_res[7:0];
    end

endmodule

// File: rtl/stat_alu.sv
module stat_alu
    import stat_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [2:0]           op_sel,
    input  logic [1:0]           size_sel,
    input  logic [DATA_W-1:0]    opnd_a,
    input  logic [DATA_W-1:0]    opnd_b,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    result,
    output logic [NUM_FLAGS-1:0] flags
);

    logic [NUM_LANES-1:0][DATA_W-1:0] lane_res;
    logic [NUM_LANES-1:0]             lane_cry;
    logic [NUM_LANES-1:0]             lane_ovf;
    logic [NUM_LANES-1:0]             lane_aux;
    logic [NUM_LANES-1:0]             lane_sgn;

    for (genvar gi = 0; gi < NUM_LANES; gi++) begin : g_lane
        localparam int LW = DATA_W >> (NUM_LANES - 1 - gi);
        logic [LW-1:0] r;

        stat_alu_lane #(.LANE_W(LW)) u_lane (
            .a   (opnd_a[LW-1:0]),
            .b   (opnd_b[LW-1:0]),
            .op  (op_sel),
            .res (r),
            .cry (lane_cry[gi]),
            .ovf (lane_ovf[gi]),
            .aux (lane_aux[gi]),
            .sgn (lane_sgn[gi])
        );

        always_comb begin
            lane_res[gi]         = '0;
            lane_res[gi][LW-1:0] = r;
        end
    end

    logic [DATA_W-1:0] sel_res;
    flags_t            sel_flags;

    stat_alu_sel #(.DATA_W(DATA_W)) u_sel (
        .size_sel  (size_sel),
        .lane_res  (lane_res),
        .lane_cry  (lane_cry),
        .lane_ovf  (lane_ovf),
        .lane_aux  (lane_aux),
        .lane_sgn  (lane_sgn),
        .sel_res   (sel_res),
        .sel_flags (sel_flags)
    );

    out_state_e state_q;
    out_state_e state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_OUT : ST_IDLE;
            ST_OUT:  state_d = in_valid ? ST_OUT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    logic [DATA_W-1:0] res_q;
    flags_t            flg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            flg_q <= '0;
        end else if (in_valid) begin
            res_q <= sel_res;
            flg_q <= sel_flags;
        end
    end

    assign out_valid = (state_q == ST_OUT);
    assign result    = res_q;
    assign flags     = flg_q;

endmodule

// File: rtl/stat_alu_chk.sv
module stat_alu_chk
    import stat_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [2:0]           op_sel,
    input logic [1:0]           size_sel,
    input logic                 out_valid,
    input logic [DATA_W-1:0]    result,
    input logic [NUM_FLAGS-1:0] flags
);

    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (out_valid == $past(in_valid)));

    // R9
    bitwise_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && out_valid && is_bitwise($past(op_sel)))
            |-> (!flags[0] && !flags[5] && !flags[2]));

    // R8
    parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flags[1] == ~^result[7:0]));

    // R6
    zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flags[3] == (result == '0)));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(in_valid)) |-> ($stable(result) && $stable(flags)));

    // R12
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && out_valid && $past(size_sel) == SZ_BYTE)
            |-> (result[DATA_W-1:DATA_W/4] == '0));

endmodule

bind stat_alu stat_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .size_sel  (size_sel),
    .out_valid (out_valid),
    .result    (result),
    .flags     (flags)
);

// File: tb/tb_stat_alu.sv
module tb_stat_alu;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 32;
    localparam int WATCHDOG   = 190000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [2:0]    op_sel = '0;
    logic [1:0]    size_sel = '0;
    logic [DW-1:0] opnd_a = '0;
    logic [DW-1:0] opnd_b = '0;
    logic          out_valid;
    logic [DW-1:0] result;
    logic [5:0]    flags;

    stat_alu #(.DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .size_sel(size_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .out_valid(out_valid), .result(result), .flags(flags)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic          pend = 1'b0;
    logic [DW-1:0] exp_res;
    logic [5:0]    exp_flg;
    logic [2:0]    exp_op;

    always @(posedge clk) cycles <= cycles + 1;

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Independent model of R3..R10, R12
    task automatic model(input logic [2:0] op, input logic [1:0] sz,
                         input logic [DW-1:0] a, input logic [DW-1:0] b,
                         output logic [DW-1:0] r, output logic [5:0] f);
        int     n;
        longint mask, am, bm, sa, sb, sr, full, half, rr;
        logic   cf, of, af;
        n    = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        mask = (longint'(1) << n) - 1;
        half = longint'(1) << (n - 1);
        am   = longint'({32'b0, a}) & mask;
        bm   = longint'({32'b0, b}) & mask;
        sa   = (am >= half) ? am - (longint'(1) << n) : am;
        sb   = (bm >= half) ? bm - (longint'(1) << n) : bm;
        cf = 1'b0; of = 1'b0; af = 1'b0; rr = 0;
        case (op)
            3'd0: begin
                full = am + bm; rr = full & mask; cf = (full > mask);
                sr = sa + sb; of = (sr >= half) || (sr < -half);
                af = ((am & 15) + (bm & 15)) > 15;
            end
            3'd1: begin
                rr = (am - bm) & mask; cf = (am < bm);
                sr = sa - sb; of = (sr >= half) || (sr < -half);
                af = (am & 15) < (bm & 15);
            end
            3'd2: rr = am & bm;
            3'd3: rr = am | bm;
            3'd4: rr = am ^ bm;
            default: rr = 0;
        endcase
        r = rr[DW-1:0];
        f[0] = cf;
        f[1] = ~^r[7:0];
        f[2] = af;
        f[3] = (rr == 0);
        f[4] = rr[n-1];
        f[5] = of;
    endtask

    task automatic check_pending();
        string rq;
        if (!pend) return;
        chk("R2", "out_valid", longint'(out_valid), 1);
        rq = (exp_op > 3'd4) ? "R10" : "R3";
        chk(rq, "result", longint'(result), longint'(exp_res));
        rq = (exp_op >= 3'd2 && exp_op <= 3'd4) ? "R9" : "R4";
        chk(rq, "carry", longint'(flags[0]), longint'(exp_flg[0]));
        rq = (exp_op >= 3'd2 && exp_op <= 3'd4) ? "R9" : "R5";
        chk(rq, "overflow", longint'(flags[5]), longint'(exp_flg[5]));
        chk("R6", "sign/zero", longint'(flags[4:3]), longint'(exp_flg[4:3]));
        chk("R7", "aux", longint'(flags[2]), longint'(exp_flg[2]));
        chk("R8", "parity", longint'(flags[1]), longint'(exp_flg[1]));
        pend = 1'b0;
    endtask

    task automatic issue(input logic [2:0] op, input logic [1:0] sz,
                         input logic [DW-1:0] a, input logic [DW-1:0] b);
        logic [DW-1:0] r;
        logic [5:0]    f;
        @(negedge clk);
        check_pending();
        op_sel = op; size_sel = sz; opnd_a = a; opnd_b = b; in_valid = 1'b1;
        model(op, sz, a, b, r, f);
        exp_res = r; exp_flg = f; exp_op = op; pend = 1'b1;
    endtask

    task automatic flush();
        @(negedge clk);
        check_pending();
        in_valid = 1'b0;
    endtask

    logic [DW-1:0] corners [12];

    initial begin
        corners[0] = 32'h0000_0000; corners[1]  = 32'h0000_0001;
        corners[2] = 32'h0000_000F; corners[3]  = 32'h0000_7FFF;
        corners[4] = 32'h0000_8000; corners[5]  = 32'h0000_FFFF;
        corners[6] = 32'h7FFF_FFFF; corners[7]  = 32'h8000_0000;
        corners[8] = 32'hFFFF_FFFF; corners[9]  = 32'h1234_5678;
        corners[10] = 32'hA5A5_00F8; corners[11] = 32'h0001_0000;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "valid in reset", longint'(out_valid), 0);
        chk("R1", "result in reset", longint'(result), 0);
        chk("R1", "flags in reset", longint'(flags), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "valid after reset", longint'(out_valid), 0);
        chk("R1", "result after reset", longint'(result), 0);
        chk("R1", "flags after reset", longint'(flags), 0);

        // 8-bit sweep, junk above the byte (R12)
        for (int op = 0; op < 5; op++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b += 3)
                    issue(3'(op), 2'd0,
                          32'(a) | (32'(a * 7 + 1) << 8),
                          32'(b) | (32'(b * 13 + 5) << 8));

        // 16- and 32-bit corners, size code 3 as 32-bit (R12)
        for (int sz = 1; sz < 4; sz++)
            for (int op = 0; op < 5; op++)
                for (int i = 0; i < 12; i++)
                    for (int j = 0; j < 12; j++)
                        issue(3'(op), 2'(sz), corners[i], corners[j]);

        // R10: unused codes
        for (int op = 5; op < 8; op++)
            for (int i = 0; i < 12; i++)
                issue(3'(op), 2'(i % 3), corners[i], corners[11 - i]);
        flush();

        // R11: no strobe, inputs wiggle, outputs hold
        for (int k = 0; k < 6; k++) begin
            op_sel = 3'(k); opnd_a = corners[k]; opnd_b = corners[k + 3];
            size_sel = 2'(k);
            @(negedge clk);
            chk("R11", "valid idle", longint'(out_valid), 0);
            chk("R11", "result held", longint'(result), longint'(exp_res));
            chk("R11", "flags held", longint'(flags), longint'(exp_flg));
        end

        // R2: single isolated strobe
        issue(3'd0, 2'd0, 32'h0000_00FF, 32'h0000_0001);
        flush();
        @(negedge clk);
        chk("R2", "valid drops", longint'(out_valid), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles >= WATCHDOG || done);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule